// File: doc/BRIEF.md
# Button-Driven Serial Greeting Sender

This block sends a fixed 14-character greeting over an asynchronous serial line. It sends one character for each press of an active-low push button. On each press it frames the next character of the greeting (one start bit, eight data bits with the least significant bit first, one stop bit) and shifts it out on a line that sits high when idle. After the last character it starts again at the first.

All logic runs on a single system clock. A divider counts from 0 to `DIV_MAX` and wraps. A bit clock toggles at every wrap, and every rising transition of that bit clock gives a one-cycle bit tick. With the default of 217 on a 50 MHz clock, one bit lasts 436 cycles, which is close to 115200 baud. The button is sampled on the bit tick, so short bounces are filtered. The character in flight is also shown on an 8-bit LED output.

Top module: `greet_tx_top`

## Requirements
- R1: Every bit slot on `tx_o`, including start and stop, lasts exactly 2*(DIV_MAX+1) clock cycles (436 by default).
- R2: A frame is one low start slot, then eight data slots carrying character bits 0 up to 7 in that order, then one high stop slot.
- R3: `tx_o` is 1 while `rst_ni` is low and whenever no frame is in progress.
- R4: A press is a high-to-low change of `btn_ni` seen between two successive bit-tick samples. Each press starts exactly one frame, and holding the button low starts no further frames.
- R5: Successive frames carry the ASCII string "Hello, World! " (0x48 0x65 0x6C 0x6C 0x6F 0x2C 0x20 0x57 0x6F 0x72 0x6C 0x64 0x21 0x20) in order, and the first press after reset sends 0x48.
- R6: After the 14th character the message position wraps, so the 15th press sends 0x48 again.
- R7: `led_o` is 0 after reset and holds the character of the current or most recent frame from its start bit onward.
- R8: A press that is detected while a frame is in progress is dropped. It starts no frame and does not move the message position.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| btn_ni | input | 1 | Push button, active low |
| tx_o | output | 1 | Serial output, idles high |
| led_o | output | 8 | Character of the current or most recent frame |

## Verification
The monitor records every cycle of each frame against the expected line level. A divider that is off by one count, or a bit order that is reversed, therefore shows up as a wrong slot width or wrong data. A full pass through the message followed by two more presses catches an index that does not wrap or wraps to the wrong entry. A button held low for many bit times catches an edge detector that acts on level instead of on change, because it would start repeated frames. A second press made in the middle of a frame catches a design that latches the request and sends a late extra character, or that skips a character of the greeting.

// File: rtl/greet_tx_pkg.sv
package greet_tx_pkg;
  localparam int MSG_LEN = 14;
  localparam int IDX_W   = $clog2(MSG_LEN + 1);

  typedef enum logic [3:0] {
    ST_IDLE  = 4'd0,
    ST_START = 4'd1,
    ST_D0    = 4'd2,
    ST_D7    = 4'd9,
    ST_STOP  = 4'd10
  } tx_state_e;

  function automatic logic [7:0] msg_char(input logic [IDX_W-1:0] idx);
    case (idx)
      4'd1:    msg_char = 8'h48;
      4'd2:    msg_char = 8'h65;
      4'd3:    msg_char = 8'h6C;
      4'd4:    msg_char = 8'h6C;
      4'd5:    msg_char = 8'h6F;
      4'd6:    msg_char = 8'h2C;
      4'd7:    msg_char = 8'h20;
      4'd8:    msg_char = 8'h57;
      4'd9:    msg_char = 8'h6F;
      4'd10:   msg_char = 8'h72;
      4'd11:   msg_char = 8'h6C;
      4'd12:   msg_char = 8'h64;
      4'd13:   msg_char = 8'h21;
      4'd14:   msg_char = 8'h20;
      default: msg_char = 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/greet_baud.sv
module greet_baud #(
  parameter int DIV_MAX = 217
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int CNT_W = $clog2(DIV_MAX + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DIV_MAX);

  logic [CNT_W-1:0] cnt_q;
  logic             bclk_q;
  logic             wrap;

  assign wrap = (cnt_q == CNT_MAX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      bclk_q <= 1'b0;
    end else if (wrap) begin
      cnt_q  <= '0;
      bclk_q <= ~bclk_q;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  // rising half of the bit clock marks a bit boundary
  assign tick_o = wrap & ~bclk_q;

  a_r1_tick_isolated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);
  a_r1_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_MAX);
endmodule

// File: rtl/greet_btn_edge.sv
module greet_btn_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic btn_ni,
  output logic press_o
);
  logic cur_q, prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q  <= 1'b1;
      prev_q <= 1'b1;
    end else if (tick_i) begin
      cur_q  <= btn_ni;
      prev_q <= cur_q;
    end
  end

  assign press_o = prev_q & ~cur_q;

  a_r4_press_one_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (press_o && tick_i) |=> !press_o);
endmodule

// File: rtl/greet_msg.sv
module greet_msg
  import greet_tx_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       adv_i,
  output logic [7:0] char_o
);
  localparam logic [IDX_W-1:0] IDX_FIRST = IDX_W'(1);
  localparam logic [IDX_W-1:0] IDX_LAST  = IDX_W'(MSG_LEN);

  logic [IDX_W-1:0] idx_q, idx_d;
  logic [7:0]       char_q;

  assign idx_d = (idx_q == IDX_LAST) ? IDX_FIRST : idx_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q  <= IDX_FIRST;
      char_q <= msg_char(IDX_FIRST);
    end else if (adv_i) begin
      idx_q  <= idx_d;
      char_q <= msg_char(idx_d);
    end
  end

  assign char_o = char_q;

  a_r6_idx_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idx_q >= IDX_FIRST) && (idx_q <= IDX_LAST));
  a_r8_idx_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i |=> $stable(idx_q));
endmodule

// File: rtl/greet_tx_fsm.sv
module greet_tx_fsm
  import greet_tx_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       press_i,
  input  logic [7:0] char_i,
  output logic       adv_o,
  output logic       tx_o,
  output logic [7:0] led_o
);
  tx_state_e  state_q, state_d;
  logic [7:0] led_q;
  logic [2:0] bit_sel;
  logic       start;

  assign start = tick_i && (state_q == ST_IDLE) && press_i;

  always_comb begin
    state_d = state_q;
    if (tick_i) begin
      case (state_q)
        ST_IDLE: if (press_i) state_d = ST_START;
        ST_STOP: state_d = ST_IDLE;
        default: begin
          if (state_q >= ST_START && state_q <= ST_D7)
            state_d = tx_state_e'(state_q + 4'd1);
          else
            state_d = ST_IDLE;  // unused encodings recover
        end
      endcase
    end
  end

  assign bit_sel = 3'(state_q - ST_D0);

  always_comb begin
    if (state_q == ST_START)
      tx_o = 1'b0;
    else if (state_q >= ST_D0 && state_q <= ST_D7)
      tx_o = char_i[bit_sel];
    else
      tx_o = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      led_q   <= 8'h00;
    end else begin
      state_q <= state_d;
      if (start) led_q <= char_i;
    end
  end

  assign adv_o = tick_i && (state_q == ST_STOP);
  assign led_o = led_q;

  a_r1_hold_between_ticks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(state_q));
  a_r4_no_start_without_press: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && state_q == ST_IDLE && !press_i) |=> state_q == ST_IDLE);
  a_r8_busy_ignores_press: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && state_q != ST_IDLE) |=> state_q != ST_START);
  a_r7_led_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start |=> $stable(led_q));
endmodule

// File: rtl/greet_tx_top.sv
module greet_tx_top #(
  parameter int DIV_MAX = 217
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       btn_ni,
  output logic       tx_o,
  output logic [7:0] led_o
);
  logic       tick, press, adv;
  logic [7:0] cur_char;

  greet_baud #(.DIV_MAX(DIV_MAX)) u_baud (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_o (tick)
  );

  greet_btn_edge u_btn (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick),
    .btn_ni  (btn_ni),
    .press_o (press)
  );

  greet_msg u_msg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .adv_i  (adv),
    .char_o (cur_char)
  );

  greet_tx_fsm u_fsm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick),
    .press_i (press),
    .char_i  (cur_char),
    .adv_o   (adv),
    .tx_o    (tx_o),
    .led_o   (led_o)
  );
endmodule

// File: tb/greet_tx_top_tb_top.sv
module greet_tx_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DIV        = 4;
  localparam int BIT        = 2 * (DIV + 1);

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       btn_n = 1'b1;
  logic       tx;
  logic [7:0] led;

  int n_chk = 0, n_fail = 0, frames = 0;
  logic [7:0] exp_q[$];
  string greeting = "Hello, World! ";

  always #(CLK_PERIOD/2) clk = ~clk;

  greet_tx_top #(.DIV_MAX(DIV)) dut_i (
    .clk_i (clk), .rst_ni (rst_n), .btn_ni (btn_n), .tx_o (tx), .led_o (led)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // driver: push the expected character, then press and release
  task automatic press(input bit push, input logic [7:0] c, input int hold_bits);
    if (push) exp_q.push_back(c);
    btn_n = 1'b0;
    wait_cyc(hold_bits * BIT);
    btn_n = 1'b1;
    wait_cyc(14 * BIT);
  endtask

  function automatic logic [7:0] nth(input int i);
    return greeting[i % 14];
  endfunction

  // monitor: capture each frame cycle by cycle
  initial begin
    @(posedge rst_n);
    forever begin
      @(negedge clk);
      if (tx === 1'b0) begin
        logic [7:0] e, got;
        int bad;
        bad = 0;
        got = 8'h00;
        if (exp_q.size() == 0) begin
          chk(1'b0, "R4 unexpected frame", frames, 0);
          e = 8'h00;
        end else begin
          e = exp_q.pop_front();
        end
        chk(led === e, "R7 led", int'(led), int'(e));
        for (int k = 0; k < 10 * BIT; k++) begin
          int j;
          logic lv;
          if (k > 0) @(negedge clk);
          j  = k / BIT;
          lv = (j == 0) ? 1'b0 : (j == 9) ? 1'b1 : e[j-1];
          if (tx !== lv) bad++;
          if (j >= 1 && j <= 8 && (k % BIT) == BIT / 2) got[j-1] = tx;
        end
        chk(bad == 0, "R1/R2 frame shape", bad, 0);
        chk(got === e, "R5 character", int'(got), int'(e));
        frames++;
      end
    end
  end

  task automatic finish_run;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    chk(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    wait_cyc(5);
    chk(tx === 1'b1, "R3 line high in reset", int'(tx), 1);
    chk(led === 8'h00, "R7 led reset", int'(led), 0);
    rst_n = 1'b1;
    wait_cyc(5 * BIT);
    chk(tx === 1'b1, "R3 idle high", int'(tx), 1);
    chk(frames == 0, "R4 no frame without press", frames, 0);

    // R5 full greeting, R6 wrap into a second pass
    for (int i = 0; i < 16; i++) press(1'b1, nth(i), 3);
    chk(frames == 16, "R6 frame count after wrap", frames, 16);
    chk(exp_q.size() == 0, "R5 queue drained", exp_q.size(), 0);

    // R4 long hold sends one character only
    press(1'b1, nth(16), 30);
    chk(frames == 17, "R4 held button", frames, 17);
    chk(tx === 1'b1, "R3 idle after hold", int'(tx), 1);

    // R8 press during a frame is dropped
    exp_q.push_back(nth(17));
    btn_n = 1'b0; wait_cyc(3 * BIT);
    btn_n = 1'b1; wait_cyc(3 * BIT);
    btn_n = 1'b0; wait_cyc(3 * BIT);
    btn_n = 1'b1; wait_cyc(14 * BIT);
    chk(frames == 18, "R8 busy press dropped", frames, 18);
    press(1'b1, nth(18), 3);
    chk(frames == 19, "R8 index not advanced", frames, 19);
    chk(exp_q.size() == 0, "R8 queue drained", exp_q.size(), 0);
    chk(tx === 1'b1, "R3 final idle", int'(tx), 1);
    finish_run();
  end
endmodule